// File: doc/BRIEF.md
# DMA Bus-Port Priority Arbiter

This block decides which of several DMA streams may use one shared bus port. Every stream raises a request and supplies a 2-bit software priority and the length of the transaction it wants to run. The arbiter picks the most urgent requester and gives it the port as a one-hot grant. When more than one requester shares the top level, the lowest stream index wins. The grant then stays put until the granted stream has signalled the last beat of its transaction. Nothing can preempt it, whatever arrives in the meantime.

A transaction is a single beat or a burst. For a burst, a bus lock output stays high for the whole grant so that the beats cannot be split on the bus. After the last beat the port spends one cycle with no grant, and then all current requests are arbitrated again with the same rules. A memory-side port and a peripheral-side port each take their own instance of this block.

Top module: `dma_port_arbiter`

## Requirements
- R1: While rst_ni is low and after its release, before any request has been seen, gnt_o is all zeros, lock_o is 0 and active_idx_o is 0.
- R2: gnt_o has at most one bit set. A grant is only issued to a stream whose req_i bit was high in the cycle before the grant appeared.
- R3: Priority encoding per stream, in prio_i[2*i+1:2*i]: 2'b11 very high, 2'b10 high, 2'b01 medium, 2'b00 low. On an idle port the requester with the highest level is granted.
- R4: Among requesters with an equal top level, the stream with the lowest index is granted.
- R5: The burst field blen_i[4*i+3:4*i] holds the beat count minus one (0 means a single beat), and it is sampled when the grant is issued. The grant stays on the same stream until that many plus one beat_done_i pulses have arrived on the granted stream's bit. A higher-priority request arriving in that time does not take the grant.
- R6: If the granted stream drops its request during its transaction, the transaction does not end early.
- R7: The clock edge that samples the last beat_done removes the grant. The cycle after that is idle, and at the next edge the pending requests are arbitrated again.
- R8: lock_o is high for every cycle of a grant whose sampled burst field is nonzero. It is low for single-beat grants and while idle.
- R9: beat_done_i bits of streams that are not granted, and every beat_done_i bit while idle, have no effect on gnt_o or lock_o.
- R10: With no request pending on an idle port, gnt_o stays all zeros and lock_o stays 0.
- R11: While any grant is active, active_idx_o equals the position of the set bit of gnt_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Per-stream request |
| prio_i | input | 16 | Per-stream 2-bit software priority |
| blen_i | input | 32 | Per-stream burst length minus one, 4 bits each |
| beat_done_i | input | 8 | Per-stream beat completion pulse |
| gnt_o | output | 8 | One-hot grant |
| lock_o | output | 1 | Bus lock during a multi-beat grant |
| active_idx_o | output | 3 | Index of the granted stream |

## Verification
A wrong beat count or a lost burst length in the internal state appears directly at the port: the grant ends early or late. The cycle of the final beat then differs from the expected drop of gnt_o, so the error shows within one cycle of the last beat_done. A wrong winner shows on gnt_o on the first cycle of the grant. A stale index shows on active_idx_o in the same cycle. A lock tied to the wrong length shows on lock_o for as long as the grant lasts.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    PRIO_LOW   = 2'b00,
    PRIO_MED   = 2'b01,
    PRIO_HIGH  = 2'b10,
    PRIO_VHIGH = 2'b11
  } prio_e;
  localparam int unsigned PRIO_W = 2;
endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
  import dma_arb_pkg::*;
#(
  parameter int unsigned N_STREAMS = 8,
  localparam int unsigned IDX_W = $clog2(N_STREAMS)
) (
  input  logic [N_STREAMS-1:0]        req_i,
  input  logic [N_STREAMS*PRIO_W-1:0] prio_i,
  output logic                        win_valid_o,
  output logic [IDX_W-1:0]            win_idx_o
);
  logic [PRIO_W-1:0] best_prio;

  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    best_prio   = '0;
    for (int i = 0; i < N_STREAMS; i++) begin
      if (req_i[i] && (!win_valid_o || prio_i[i*PRIO_W +: PRIO_W] > best_prio)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(i);
        best_prio   = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/dma_arb_beat_cnt.sv
module dma_arb_beat_cnt #(
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             beat_i,
  output logic             last_o,
  output logic             multi_o
);
  logic [LEN_W-1:0] cnt_q, len_q;

  assign last_o  = beat_i && (cnt_q == len_q);
  assign multi_o = (len_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      len_q <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
      len_q <= len_i;
    end else if (beat_i) begin
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
    end
  end

  // R5: beat count never runs past the sampled length
  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= len_q);
endmodule

// File: rtl/dma_port_arbiter.sv
module dma_port_arbiter
  import dma_arb_pkg::*;
#(
  parameter int unsigned N_STREAMS = 8,
  parameter int unsigned LEN_W     = 4,
  localparam int unsigned IDX_W    = $clog2(N_STREAMS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_STREAMS-1:0]        req_i,
  input  logic [N_STREAMS*PRIO_W-1:0] prio_i,
  input  logic [N_STREAMS*LEN_W-1:0]  blen_i,
  input  logic [N_STREAMS-1:0]        beat_done_i,
  output logic [N_STREAMS-1:0]        gnt_o,
  output logic                        lock_o,
  output logic [IDX_W-1:0]            active_idx_o
);
  logic [N_STREAMS-1:0] gnt_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 busy, win_valid, load, beat, last, multi;
  logic [IDX_W-1:0]     win_idx;

  dma_arb_pick #(.N_STREAMS(N_STREAMS)) u_pick (
    .req_i       (req_i),
    .prio_i      (prio_i),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx)
  );

  assign busy = |gnt_q;
  assign load = !busy && win_valid;
  assign beat = busy && beat_done_i[idx_q];

  dma_arb_beat_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .len_i   (blen_i[win_idx*LEN_W +: LEN_W]),
    .beat_i  (beat),
    .last_o  (last),
    .multi_o (multi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q <= '0;
      idx_q <= '0;
    end else if (load) begin
      gnt_q <= N_STREAMS'(1) << win_idx;
      idx_q <= win_idx;
    end else if (last) begin
      gnt_q <= '0;
    end
  end

  assign gnt_o        = gnt_q;
  assign lock_o       = busy && multi;
  assign active_idx_o = idx_q;

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_q));
  p_gnt_from_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(gnt_q) == '0) |-> ((gnt_q & $past(req_i)) != '0));
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !last) |=> $stable(gnt_q));
  p_idle_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && last) |=> (gnt_q == '0));
  p_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> busy);
  p_idx_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> gnt_q[idx_q]);
endmodule

// File: tb/dma_port_arbiter_bench.sv
module dma_port_arbiter_bench;
  localparam int N = 8;
  localparam int LW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  req_i = '0;
  logic [2*N-1:0] prio_i = '0;
  logic [LW*N-1:0] blen_i = '0;
  logic [N-1:0]  beat_done_i = '0;
  logic [N-1:0]  gnt_o;
  logic          lock_o;
  logic [2:0]    active_idx_o;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_busy = 0;
  int m_idx = 0, m_len = 0, m_cnt = 0;

  always #10 clk_i = ~clk_i;

  dma_port_arbiter u_dma_port_arbiter (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .prio_i(prio_i),
    .blen_i(blen_i), .beat_done_i(beat_done_i), .gnt_o(gnt_o),
    .lock_o(lock_o), .active_idx_o(active_idx_o)
  );

  function automatic int winner(logic [N-1:0] r, logic [2*N-1:0] p);
    for (int lvl = 3; lvl >= 0; lvl--)
      for (int i = 0; i < N; i++)
        if (r[i] && int'(p[2*i +: 2]) == lvl) return i;
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle();
    int w;
    @(posedge clk_i);
    if (!m_busy) begin
      w = winner(req_i, prio_i);
      if (w >= 0) begin
        m_busy = 1; m_idx = w; m_len = int'(blen_i[LW*w +: LW]); m_cnt = 0;
      end
    end else if (beat_done_i[m_idx]) begin
      if (m_cnt == m_len) m_busy = 0;
      else m_cnt++;
    end
    @(negedge clk_i);
    chk("R2/R3/R4/R5 gnt model", 32'(gnt_o), m_busy ? (32'd1 << m_idx) : 32'd0);
    chk("R8 lock model", 32'(lock_o), 32'(m_busy && m_len != 0));
    if (m_busy) chk("R11 idx model", 32'(active_idx_o), 32'(m_idx));
  endtask

  task automatic drain();
    req_i = '0; beat_done_i = '1;
    repeat (20) cycle();
    beat_done_i = '0;
    cycle();
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    chk("R1 gnt in reset", 32'(gnt_o), 0);
    chk("R1 lock in reset", 32'(lock_o), 0);
    chk("R1 idx in reset", 32'(active_idx_o), 0);
    rst_ni = 1'b1;
    cycle();
    chk("R1 gnt after release", 32'(gnt_o), 0);

    // R10 and R9: idle with beat pulses
    beat_done_i = '1;
    repeat (3) cycle();
    chk("R10 idle gnt", 32'(gnt_o), 0);
    chk("R9 idle beat ignored lock", 32'(lock_o), 0);
    beat_done_i = '0;

    // R3: stream 2 medium vs stream 5 very high
    prio_i[2*2 +: 2] = 2'b01; prio_i[2*5 +: 2] = 2'b11;
    req_i = 8'h24;
    cycle();
    chk("R3 very high wins", 32'(gnt_o), 32'h20);
    drain();

    // R4: streams 3,4,6 all high
    prio_i = '0;
    prio_i[2*3 +: 2] = 2'b10; prio_i[2*4 +: 2] = 2'b10; prio_i[2*6 +: 2] = 2'b10;
    req_i = 8'h58;
    cycle();
    chk("R4 lowest index on tie", 32'(gnt_o), 32'h08);
    chk("R11 idx on tie", 32'(active_idx_o), 3);
    drain();

    // R5/R6/R7/R8/R9: 4-beat burst on stream 1, low priority
    prio_i = '0; blen_i = '0;
    blen_i[LW*1 +: LW] = 4'd3;
    prio_i[2*0 +: 2] = 2'b11;
    req_i = 8'h02;
    cycle();
    chk("R5 burst granted", 32'(gnt_o), 32'h02);
    chk("R8 lock on burst", 32'(lock_o), 1);
    req_i = 8'h01; beat_done_i = 8'h01;
    cycle();
    chk("R6 drop keeps grant", 32'(gnt_o), 32'h02);
    chk("R9 foreign beat ignored", 32'(lock_o), 1);
    beat_done_i = 8'h02;
    repeat (3) cycle();
    chk("R5 no preemption before last beat", 32'(gnt_o), 32'h02);
    cycle();
    chk("R7 idle after last beat", 32'(gnt_o), 0);
    chk("R8 lock off when idle", 32'(lock_o), 0);
    beat_done_i = '0;
    cycle();
    chk("R7 re-arbitration", 32'(gnt_o), 32'h01);
    chk("R8 no lock single beat", 32'(lock_o), 0);
    drain();

    // random phase
    for (int k = 0; k < 4000; k++) begin
      req_i = 8'($urandom);
      beat_done_i = 8'($urandom);
      if (($urandom % 8) == 0) prio_i = 16'($urandom);
      for (int s = 0; s < N; s++)
        if (($urandom % 16) == 0) blen_i[LW*s +: LW] = 4'($urandom);
        else if (($urandom % 4) == 0) blen_i[LW*s +: LW] = 4'($urandom % 4);
      cycle();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule